// File: doc/BRIEF.md
# Serial-In Latched Parallel-Out Register

This block turns a serial bit stream into a parallel word in two stages. A shift chain moves one bit in per rising edge of a shift strobe. A separate storage register copies the whole chain when a latch strobe rises. The parallel word is presented from the storage register, so software-visible or downstream-visible outputs change only at latch time while new data is being shifted in behind them.

Both strobes, the active-low chain clear and the active-high output disable arrive from outside the system clock domain. Each one passes through a two-flop synchronizer. The strobes are then edge-detected into single-cycle enables. A serial cascade output mirrors the last chain stage so that several instances can be chained. The cascade keeps running while the parallel outputs are disabled. Disabled outputs are modelled as a per-bit enable flag that goes low, with the data bus forced to zero.

Top module: `sipo_latch_reg`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `par_out`, `par_oe` and `cascade_out` are all zero. The chain and the storage register reset to zero.
- R2: Each low-to-high transition of `shift_strobe` causes exactly one shift, however long the strobe stays high. The same holds for `latch_strobe` and its load. The action takes effect on the third rising `clk` edge after the strobe is first sampled high.
- R3: On a shift, chain stage 0 takes `ser_in` as sampled on the shift edge, and stage i takes the old stage i-1. `par_out` bit 0 maps to stage 0, and bit WIDTH-1 maps to the last stage.
- R4: Without a shift or a clear, the chain holds its contents.
- R5: A low `clear_n` zeroes every chain stage, and it wins over a shift in the same cycle. It never alters the storage register.
- R6: A latch copies the current chain into the storage register. At all other times the storage register holds.
- R7: When both strobes rise together, the storage register receives the chain value from before the simultaneous shift.
- R8: When the synchronized `out_disable` is high, `par_oe` is all zeros and `par_out` is zero. When it is low, `par_oe` is all ones and `par_out` equals the storage register, one cycle later.
- R9: `cascade_out` always equals the last chain stage. It is unaffected by `out_disable` and by latching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data in |
| shift_strobe | input | 1 | Shift clock, asynchronous; its rising edge shifts |
| latch_strobe | input | 1 | Latch clock, asynchronous; its rising edge loads storage |
| clear_n | input | 1 | Active-low chain clear, asynchronous |
| out_disable | input | 1 | Active-high parallel output disable, asynchronous |
| par_out | output | WIDTH | Latched parallel word (zero when disabled) |
| par_oe | output | WIDTH | Per-bit output-valid flags |
| cascade_out | output | 1 | Last chain stage, for cascading |

## Verification
The assertions assume that `ser_in` is stable on the system clock edge where the synchronized shift enable is high. The bench keeps `ser_in` unchanged from the moment it raises `shift_strobe` until several cycles after lowering it. The strobe checks also assume that each strobe level lasts at least a couple of system cycles. For that reason, every strobe pulse and clear pulse in the stimulus spans at least three clock periods. Each pulse is then followed by an idle gap long enough for the synchronizers and the output register to settle before any output is compared.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic shift_en;
    logic latch_en;
    logic clr;
    logic dis;
  } sipo_ctl_t;
endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int unsigned STAGES      = 2,
  parameter bit          RST_VAL     = 1'b0,
  parameter bit          DETECT_RISE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned LEN = STAGES + (DETECT_RISE ? 1 : 0);

  logic [LEN-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {LEN{RST_VAL}};
    else     pipe <= {pipe[LEN-2:0], d};
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign q = pipe[STAGES-1] & ~pipe[STAGES];

      // R2: a detected edge lasts exactly one cycle
      a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        q |=> !q);
    end else begin : g_level
      assign q = pipe[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sipo_chain.sv
module sipo_chain #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             ser_in,
  output logic [WIDTH-1:0] chain_q
);
  always_ff @(posedge clk) begin
    if (rst || clr)    chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[WIDTH-2:0], ser_in};
  end

  a_r3_shift_moves: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !clr) |=> (chain_q == {$past(chain_q[WIDTH-2:0]), $past(ser_in)}));

  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clr) |=> $stable(chain_q));

  a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
    clr |=> (chain_q == '0));
endmodule

// File: rtl/sipo_store.sv
module sipo_store #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             latch_en,
  input  logic [WIDTH-1:0] chain_q,
  output logic [WIDTH-1:0] store_q
);
  always_ff @(posedge clk) begin
    if (rst)           store_q <= '0;
    else if (latch_en) store_q <= chain_q;
  end

  // R6 / R7: the loaded value is the chain as it stood before this edge
  a_r6_latch_copies: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (store_q == $past(chain_q)));

  a_r6_store_holds: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(store_q));
endmodule

// File: rtl/sipo_outstage.sv
module sipo_outstage #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dis,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] par_out,
  output logic [WIDTH-1:0] par_oe
);
  always_ff @(posedge clk) begin
    if (rst) begin
      par_out <= '0;
      par_oe  <= '0;
    end else begin
      par_out <= dis ? '0 : store_q;
      par_oe  <= {WIDTH{~dis}};
    end
  end

  a_r8_disabled_off: assert property (@(posedge clk) disable iff (rst)
    dis |=> (par_oe == '0 && par_out == '0));

  a_r8_enabled_drive: assert property (@(posedge clk) disable iff (rst)
    !dis |=> (par_oe == '1 && par_out == $past(store_q)));
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             shift_strobe,
  input  logic             latch_strobe,
  input  logic             clear_n,
  input  logic             out_disable,
  output logic [WIDTH-1:0] par_out,
  output logic [WIDTH-1:0] par_oe,
  output logic             cascade_out
);
  import sipo_pkg::*;

  sipo_ctl_t        ctl;
  logic             clear_n_s;
  logic [WIDTH-1:0] chain_q;
  logic [WIDTH-1:0] store_q;

  sipo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_shift_sync (
    .clk(clk), .rst(rst), .d(shift_strobe), .q(ctl.shift_en));

  sipo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .DETECT_RISE(1'b1)) u_latch_sync (
    .clk(clk), .rst(rst), .d(latch_strobe), .q(ctl.latch_en));

  sipo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_clear_sync (
    .clk(clk), .rst(rst), .d(clear_n), .q(clear_n_s));

  sipo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .DETECT_RISE(1'b0)) u_dis_sync (
    .clk(clk), .rst(rst), .d(out_disable), .q(ctl.dis));

  assign ctl.clr = ~clear_n_s;

  sipo_chain #(.WIDTH(WIDTH)) u_chain (
    .clk(clk), .rst(rst), .clr(ctl.clr), .shift_en(ctl.shift_en),
    .ser_in(ser_in), .chain_q(chain_q));

  sipo_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .latch_en(ctl.latch_en),
    .chain_q(chain_q), .store_q(store_q));

  sipo_outstage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst(rst), .dis(ctl.dis), .store_q(store_q),
    .par_out(par_out), .par_oe(par_oe));

  assign cascade_out = chain_q[WIDTH-1];

  // R9: cascade tracks the last stage, whatever the disable does
  a_r9_cascade_follows: assert property (@(posedge clk) disable iff (rst)
    ctl.shift_en && !ctl.clr |=> cascade_out == $past(chain_q[WIDTH-2]));

  // R5: clearing never disturbs the storage register
  a_r5_store_untouched: assert property (@(posedge clk) disable iff (rst)
    (ctl.clr && !ctl.latch_en) |=> $stable(store_q));

  // R1: the cycle right after reset shows all outputs low
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (par_out == '0 && par_oe == '0));
endmodule

// File: tb/sipo_latch_reg_bench.sv
module sipo_latch_reg_bench;
  localparam int unsigned W = 8;

  typedef struct {
    logic [W-1:0] par;
    logic [W-1:0] oe;
    logic         casc;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ser_in = 1'b0;
  logic         shift_strobe = 1'b0;
  logic         latch_strobe = 1'b0;
  logic         clear_n = 1'b1;
  logic         out_disable = 1'b0;
  logic [W-1:0] par_out;
  logic [W-1:0] par_oe;
  logic         cascade_out;

  exp_t         q[$];
  int           n_checks = 0;
  int           n_fails = 0;
  bit           done = 1'b0;
  logic [W-1:0] chain_m = '0;
  logic [W-1:0] store_m = '0;
  bit           dis_m = 1'b0;

  always #10 clk = ~clk;

  sipo_latch_reg #(.WIDTH(W)) u_sipo_latch_reg (
    .clk(clk), .rst(rst), .ser_in(ser_in), .shift_strobe(shift_strobe),
    .latch_strobe(latch_strobe), .clear_n(clear_n), .out_disable(out_disable),
    .par_out(par_out), .par_oe(par_oe), .cascade_out(cascade_out));

  task automatic push(input string tag);
    exp_t e;
    e.par  = dis_m ? '0 : store_m;
    e.oe   = dis_m ? '0 : '1;
    e.casc = chain_m[W-1];
    e.tag  = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic pulse(input bit do_shift, input bit do_latch, input bit b, input int hold);
    @(negedge clk);
    ser_in = b;
    shift_strobe = do_shift;
    latch_strobe = do_latch;
    repeat (hold) @(negedge clk);
    shift_strobe = 1'b0;
    latch_strobe = 1'b0;
    repeat (6) @(negedge clk);
    if (do_latch) store_m = chain_m;
    if (do_shift) chain_m = {chain_m[W-2:0], b};
  endtask

  task automatic clear_pulse(input bit with_shift);
    @(negedge clk);
    clear_n = 1'b0;
    ser_in = 1'b1;
    shift_strobe = with_shift;
    repeat (3) @(negedge clk);
    clear_n = 1'b1;
    shift_strobe = 1'b0;
    repeat (6) @(negedge clk);
    ser_in = 1'b0;
    chain_m = '0;
  endtask

  task automatic set_dis(input bit v);
    @(negedge clk);
    out_disable = v;
    repeat (6) @(negedge clk);
    dis_m = v;
  endtask

  task automatic load_word(input logic [W-1:0] w);
    for (int i = 0; i < W; i++) pulse(1'b1, 1'b0, w[W-1-i], 3);
  endtask

  // monitor: compares each queued expectation away from the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (par_out !== e.par || par_oe !== e.oe || cascade_out !== e.casc) begin
          n_fails++;
          $display("FAIL %s: par_out=%h oe=%h casc=%b expected par_out=%h oe=%h casc=%b",
                   e.tag, par_out, par_oe, cascade_out, e.par, e.oe, e.casc);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, outputs disabled-looking and zero
    repeat (3) @(negedge clk);
    dis_m = 1'b1;
    push("R1 during reset");
    @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    dis_m = 1'b0;
    push("R1 after reset, R8 enabled zero");

    // R3 ordering: word arrives MSB first, bit0 holds the last bit sent
    load_word(8'b1011_0011);
    push("R9 cascade after load");
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R3 R6 latched word 0xB3");

    // R6: shift without latch leaves outputs untouched, cascade moves
    pulse(1'b1, 1'b0, 1'b1, 3);
    push("R6 store holds, R9 cascade moves");

    // R2: long-held strobe gives exactly one shift
    pulse(1'b1, 1'b0, 1'b0, 14);
    pulse(1'b0, 1'b1, 1'b0, 14);
    push("R2 one shift and one load per rising edge");

    // R4: idle period, then latch shows the same chain
    repeat (20) @(negedge clk);
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R4 chain held while idle");

    // R5: clear zeroes the chain but not the storage register
    clear_pulse(1'b0);
    push("R5 clear leaves store");
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R5 latched zero after clear");

    // R7: simultaneous strobes capture pre-shift chain
    load_word(8'h5A);
    pulse(1'b1, 1'b1, 1'b1, 3);
    push("R7 simultaneous latch sees old chain 0x5A");
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R7 later latch sees shifted chain");

    // R8 / R9: disable gates parallel outputs, cascade keeps running
    set_dis(1'b1);
    push("R8 disabled outputs off");
    pulse(1'b1, 1'b0, 1'b0, 3);
    pulse(1'b1, 1'b0, 1'b1, 3);
    push("R9 cascade runs while disabled");
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R8 latch while disabled stays hidden");
    set_dis(1'b0);
    push("R8 re-enabled shows store");

    // R5: clear wins over a coincident shift
    load_word(8'hFF);
    clear_pulse(1'b1);
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R5 clear beats shift");

    // R3: single one walks through the chain
    pulse(1'b1, 1'b0, 1'b1, 3);
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R3 first stage takes ser_in");
    for (int i = 0; i < W - 1; i++) pulse(1'b1, 1'b0, 1'b0, 3);
    pulse(1'b0, 1'b1, 1'b0, 3);
    push("R3 R9 bit reaches last stage");

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule